// File: doc/BRIEF.md
# Bit-Reversed Write Address Generator

This block computes the effective address and the pointer write-back value for a data write, with bit-reversed sequencing for the data shuffle of a radix-2 FFT. A 16-bit control word supplies an enable bit and a 15-bit pivot modifier expressed in words. The modifier is normally half the buffer length. When reversal applies, the pointer's word index is added to the modifier with the carry running from the most significant bit toward the least significant bit. Successive writes therefore visit the buffer in bit-reversed order, while the pointer and the address themselves stay in normal bit order.

Reversal applies only when three conditions hold together: a word write, a pre-increment or post-increment indirect mode, and a pointer that is not the stack register. In every other case the block produces the ordinary address and the ordinary pointer update. An active flag tells the surrounding write path that reversal has taken over, so that modulo correction on that path is disabled. All outputs are registered and appear one cycle after the inputs. For a buffer of 2^N bytes, the caller keeps the start address aligned, with its low N bits zero.

Top module: `brw_addr_gen`

## Requirements
- R1: Reversal is active only when `ptr_idx` is not 15, bit 15 of `ctrl_word` is 1, and `amode` is 3 (post-increment) or 5 (pre-increment).
- R2: When `is_byte` is 1, reversal is never active, and the step of the ordinary update is 1 instead of 2.
- R3: When active, `ptr_wb` = {S, 0}, where S is the 15-bit sum of `ptr_val[15:1]` and `ctrl_word[14:0]`. In this sum the carry out of each bit enters the next lower bit, and the carry out of bit 0 is dropped. The ordinary ±2 step is not applied.
- R4: When active with post-increment, `ea_out` = `ptr_val` with bit 0 cleared. When active with pre-increment, `ea_out` equals `ptr_wb`.
- R5: When active, bit 0 of both `ea_out` and `ptr_wb` is 0, whatever bit 0 of `ptr_val` is.
- R6: `rev_active` is 1 exactly when the inputs of the previous cycle met the R1 and R2 conditions. This flag disables modulo correction on the write path.
- R7: When not active, the ordinary update applies, with step s = 2 for words and 1 for bytes:
  - post-increment (3): `ea_out` = ptr and `ptr_wb` = ptr+s.
  - pre-increment (5): both outputs are ptr+s.
  - post-decrement (2): `ea_out` = ptr and `ptr_wb` = ptr−s.
  - pre-decrement (4): both outputs are ptr−s.
  - modes 0, 1, 6 and 7: both outputs equal ptr.
  - All arithmetic wraps modulo 2^16.
- R8: The outputs are registered with one cycle of latency. While `rst_n` is low, all outputs are 0.
- R9: With the modifier set to 4, a start address of 0, post-increment word writes and `ptr_wb` fed back as the next pointer, the word addresses are 0, 4, 2, 6, 1, 5, 3, 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ptr_val | input | 16 | Current pointer register value (byte address) |
| ptr_idx | input | 4 | Index of the pointer register; 15 is the stack |
| ctrl_word | input | 16 | Bit 15 enables reversal; bits 14:0 hold the word modifier |
| amode | input | 3 | Addressing mode code (see R7) |
| is_byte | input | 1 | 1 for a byte write, 0 for a word write |
| ea_out | output | 16 | Effective byte address of the write |
| ptr_wb | output | 16 | Value written back to the pointer register |
| rev_active | output | 1 | Reversal in use; modulo correction on the write path is disabled |

## Verification
The assertions take for granted that every input is a known value that is stable across the capturing clock edge. They also take for granted that `rev_active` and the two addresses describe the same captured request. The bench changes inputs only on falling clock edges and holds every input at a defined value, including during reset, so each rising edge sees one coherent request. The random stimulus uses arbitrary modifiers and unaligned pointers. These stay within the assumptions because the arithmetic of R3 is defined for any operand, not only for aligned buffers.

// File: rtl/brw_pkg.sv
package brw_pkg;
   typedef enum logic [2:0] {
      AM_DIRECT  = 3'd0,
      AM_IND     = 3'd1,
      AM_POSTDEC = 3'd2,
      AM_POSTINC = 3'd3,
      AM_PREDEC  = 3'd4,
      AM_PREINC  = 3'd5,
      AM_OFFSET  = 3'd6,
      AM_RSVD    = 3'd7
   } amode_e;

   localparam int unsigned MODE_W = 3;

   function automatic logic is_inc_mode(input logic [MODE_W-1:0] m);
      return (m == AM_POSTINC) || (m == AM_PREINC);
   endfunction
endpackage

// File: rtl/brw_qualify.sv
module brw_qualify
   import brw_pkg::*;
#(
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned CW        = 16,
   parameter int unsigned EN_BIT    = 15,
   parameter int unsigned STACK_IDX = 15
) (
   input  logic [IDX_W-1:0]  ptr_idx,
   input  logic [CW-1:0]     ctrl_word,
   input  logic [MODE_W-1:0] amode,
   input  logic              is_byte,
   output logic              use_rev,
   output logic              pre_mod
);
   localparam logic [IDX_W-1:0] STACK_SEL = IDX_W'(STACK_IDX);

   if (EN_BIT >= CW) begin : g_bad_en
      $error("brw_qualify: EN_BIT outside control word");
   end
   if (STACK_IDX >= (1 << IDX_W)) begin : g_bad_stack
      $error("brw_qualify: STACK_IDX not reachable by IDX_W");
   end

   logic idx_ok, en_ok, mode_ok;

   always_comb begin
      idx_ok  = (ptr_idx != STACK_SEL);
      en_ok   = ctrl_word[EN_BIT];
      mode_ok = is_inc_mode(amode);
      use_rev = idx_ok && en_ok && mode_ok && !is_byte;
      pre_mod = (amode == AM_PREINC);
   end
endmodule

// File: rtl/brw_revadd.sv
module brw_revadd #(
   parameter int unsigned W     = 15,
   parameter int unsigned STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   if (W < 1) begin : g_bad_w
      $error("brw_revadd: W must be at least 1");
   end
   if (STYLE > 1) begin : g_bad_style
      $error("brw_revadd: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_ripple
      always_comb begin
         logic cy;
         cy  = 1'b0;
         sum = '0;
         for (int i = W - 1; i >= 0; i--) begin
            sum[i] = a[i] ^ b[i] ^ cy;
            cy     = (a[i] & b[i]) | (a[i] & cy) | (b[i] & cy);
         end
      end
   end else begin : g_mirror
      logic [W-1:0] ar, br, sr;
      always_comb begin
         for (int i = 0; i < W; i++) begin
            ar[i] = a[W-1-i];
            br[i] = b[W-1-i];
         end
         sr = ar + br;
         for (int i = 0; i < W; i++) begin
            sum[i] = sr[W-1-i];
         end
      end
   end
endmodule

// File: rtl/brw_linear.sv
module brw_linear
   import brw_pkg::*;
#(
   parameter int unsigned AW = 16
) (
   input  logic [AW-1:0]     ptr,
   input  logic [MODE_W-1:0] amode,
   input  logic              is_byte,
   output logic [AW-1:0]     ea,
   output logic [AW-1:0]     nxt
);
   localparam logic [AW-1:0] STEP_W = AW'(2);
   localparam logic [AW-1:0] STEP_B = AW'(1);

   logic [AW-1:0] step, up, dn;

   always_comb begin
      step = is_byte ? STEP_B : STEP_W;
      up   = ptr + step;
      dn   = ptr - step;
      unique case (amode_e'(amode))
         AM_POSTINC: begin ea = ptr; nxt = up;  end
         AM_PREINC:  begin ea = up;  nxt = up;  end
         AM_POSTDEC: begin ea = ptr; nxt = dn;  end
         AM_PREDEC:  begin ea = dn;  nxt = dn;  end
         default:    begin ea = ptr; nxt = ptr; end
      endcase
   end
endmodule

// File: rtl/brw_addr_gen.sv
module brw_addr_gen
   import brw_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned MW        = 15,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned STACK_IDX = 15,
   parameter int unsigned ADD_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     ptr_val,
   input  logic [IDX_W-1:0]  ptr_idx,
   input  logic [MW:0]       ctrl_word,
   input  logic [2:0]        amode,
   input  logic              is_byte,
   output logic [AW-1:0]     ea_out,
   output logic [AW-1:0]     ptr_wb,
   output logic              rev_active
);
   localparam int unsigned WW = AW - 1;
   localparam int unsigned CW = MW + 1;

   if (MW != WW) begin : g_bad_mw
      $error("brw_addr_gen: modifier width must equal word-index width");
   end
   if (AW < 2) begin : g_bad_aw
      $error("brw_addr_gen: AW too small");
   end

   logic          use_rev, pre_mod;
   logic [WW-1:0] wsum;
   logic [AW-1:0] lin_ea, lin_nxt, rev_ea, rev_nxt, ea_d, nxt_d;

   brw_qualify #(
      .IDX_W(IDX_W), .CW(CW), .EN_BIT(MW), .STACK_IDX(STACK_IDX)
   ) u_qual (
      .ptr_idx(ptr_idx), .ctrl_word(ctrl_word), .amode(amode),
      .is_byte(is_byte), .use_rev(use_rev), .pre_mod(pre_mod)
   );

   brw_revadd #(.W(WW), .STYLE(ADD_STYLE)) u_radd (
      .a(ptr_val[AW-1:1]), .b(ctrl_word[MW-1:0]), .sum(wsum)
   );

   brw_linear #(.AW(AW)) u_lin (
      .ptr(ptr_val), .amode(amode), .is_byte(is_byte),
      .ea(lin_ea), .nxt(lin_nxt)
   );

   always_comb begin
      rev_nxt = {wsum, 1'b0};
      rev_ea  = pre_mod ? rev_nxt : {ptr_val[AW-1:1], 1'b0};
      ea_d    = use_rev ? rev_ea  : lin_ea;
      nxt_d   = use_rev ? rev_nxt : lin_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_out     <= '0;
         ptr_wb     <= '0;
         rev_active <= 1'b0;
      end else begin
         ea_out     <= ea_d;
         ptr_wb     <= nxt_d;
         rev_active <= use_rev;
      end
   end

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assert_lsb_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rev_active |-> (ea_out[0] == 1'b0 && ptr_wb[0] == 1'b0));

   assert_no_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && rev_active) |-> !$past(is_byte));

   assert_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && rev_active) |->
         ($past(ptr_idx) != IDX_W'(STACK_IDX) && $past(ctrl_word[MW])));

   assert_post_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && rev_active && $past(amode) == AM_POSTINC) |->
         ea_out == {$past(ptr_val[AW-1:1]), 1'b0});

   assert_pre_ea_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && rev_active && $past(amode) == AM_PREINC) |-> ea_out == ptr_wb);

   assert_hold_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(amode) == AM_IND) |->
         (ptr_wb == $past(ptr_val) && ea_out == $past(ptr_val) && !rev_active));

   assert_active_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(ptr_idx) != IDX_W'(STACK_IDX) && $past(ctrl_word[MW]) &&
       $past(amode) == AM_POSTINC && !$past(is_byte)) |-> rev_active);
endmodule

// File: tb/brw_addr_gen_tb.sv
`timescale 1ns/1ps
module brw_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ptr_val = '0;
   logic [3:0]  ptr_idx = '0;
   logic [15:0] ctrl_word = '0;
   logic [2:0]  amode = '0;
   logic        is_byte = 1'b0;
   logic [15:0] ea_out, ptr_wb;
   logic        rev_active;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   brw_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .ptr_val(ptr_val), .ptr_idx(ptr_idx),
      .ctrl_word(ctrl_word), .amode(amode), .is_byte(is_byte),
      .ea_out(ea_out), .ptr_wb(ptr_wb), .rev_active(rev_active)
   );

   typedef struct {
      logic [15:0] ea;
      logic [15:0] wb;
      logic        act;
      string       tag;
   } exp_t;
   exp_t pend[$];

   function automatic int mirror15(input int v);
      int r = 0;
      for (int i = 0; i < 15; i++) if (v[i]) r = r | (1 << (14 - i));
      return r;
   endfunction

   function automatic exp_t model(input logic [15:0] p, input logic [3:0] idx,
                                  input logic [15:0] cw, input logic [2:0] m,
                                  input logic byt, input string tag);
      exp_t e;
      logic [15:0] s;
      int w, sum;
      e.tag = tag;
      s = byt ? 16'd1 : 16'd2;
      e.act = (idx != 4'd15) && cw[15] && (m == 3'd3 || m == 3'd5) && !byt;
      if (e.act) begin
         w = int'(p[15:1]);
         sum = mirror15((mirror15(w) + mirror15(int'(cw[14:0]))) & 32'h7fff);
         e.wb = 16'(sum * 2);
         e.ea = (m == 3'd5) ? e.wb : {p[15:1], 1'b0};
      end else begin
         case (m)
            3'd3: begin e.ea = p; e.wb = p + s; end
            3'd5: begin e.ea = p + s; e.wb = p + s; end
            3'd2: begin e.ea = p; e.wb = p - s; end
            3'd4: begin e.ea = p - s; e.wb = p - s; end
            default: begin e.ea = p; e.wb = p; end
         endcase
      end
      return e;
   endfunction

   task automatic check(input string tag, input string what, input logic [15:0] act,
                        input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_pending();
      exp_t e;
      if (pend.size() != 0) begin
         e = pend.pop_front();
         check(e.tag, "ea_out", ea_out, e.ea);
         check(e.tag, "ptr_wb", ptr_wb, e.wb);
         check(e.tag, "rev_active", 16'(rev_active), 16'(e.act));
      end
   endtask

   task automatic drive(input logic [15:0] p, input logic [3:0] idx,
                        input logic [15:0] cw, input logic [2:0] m,
                        input logic byt, input string tag);
      @(negedge clk);
      compare_pending();
      ptr_val = p; ptr_idx = idx; ctrl_word = cw; amode = m; is_byte = byt;
      pend.push_back(model(p, idx, cw, m, byt, tag));
   endtask

   task automatic settle();
      @(negedge clk);
      compare_pending();
   endtask

   initial begin
      #(200000 * 4);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] p;
      int order[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
      // R8: reset holds outputs at zero even with an active request applied
      ptr_val = 16'h1234; ptr_idx = 4'd2; ctrl_word = 16'h8004; amode = 3'd3;
      repeat (3) @(negedge clk);
      check("R8", "reset ea_out", ea_out, 16'h0);
      check("R8", "reset ptr_wb", ptr_wb, 16'h0);
      check("R8", "reset rev_active", 16'(rev_active), 16'h0);
      rst_n = 1'b1;

      // R1: gating conditions
      drive(16'h0010, 4'd15, 16'h8004, 3'd3, 1'b0, "R1 stack");
      drive(16'h0010, 4'd3,  16'h0004, 3'd3, 1'b0, "R1 disabled");
      drive(16'h0010, 4'd3,  16'h8004, 3'd2, 1'b0, "R1 postdec");
      drive(16'h0010, 4'd3,  16'h8004, 3'd6, 1'b0, "R1 offset");
      drive(16'h0010, 4'd3,  16'h8004, 3'd3, 1'b0, "R1 enabled");
      // R2: byte writes fall back to the ordinary step of 1
      drive(16'h0010, 4'd3,  16'h8004, 3'd3, 1'b1, "R2 byte postinc");
      drive(16'h0021, 4'd3,  16'h8004, 3'd5, 1'b1, "R2 byte preinc");
      // R3: reverse carry, including a carry dropped past bit 1
      drive(16'h000E, 4'd1,  16'h8004, 3'd3, 1'b0, "R3 wrap");
      drive(16'h0006, 4'd1,  16'h8003, 3'd3, 1'b0, "R3 chain");
      drive(16'h7FFE, 4'd1,  16'hFFFF, 3'd3, 1'b0, "R3 wide");
      // R4: pre versus post increment
      drive(16'h0108, 4'd4,  16'h8010, 3'd5, 1'b0, "R4 preinc");
      drive(16'h0108, 4'd4,  16'h8010, 3'd3, 1'b0, "R4 postinc");
      // R5: odd pointer produces even addresses
      drive(16'h0009, 4'd5,  16'h8004, 3'd3, 1'b0, "R5 odd post");
      drive(16'h0009, 4'd5,  16'h8004, 3'd5, 1'b0, "R5 odd pre");
      // R6 and R7: flag and ordinary updates with wrap
      drive(16'hFFFE, 4'd0,  16'h0000, 3'd3, 1'b0, "R7 inc wrap");
      drive(16'h0000, 4'd0,  16'h0000, 3'd4, 1'b0, "R7 predec wrap");
      drive(16'h0040, 4'd0,  16'h8004, 3'd1, 1'b0, "R6 plain indirect");
      drive(16'h0040, 4'd0,  16'h8004, 3'd7, 1'b0, "R7 reserved");
      settle();

      // R9: 8-point walk with feedback
      p = 16'h0000;
      for (int k = 0; k < 8; k++) begin
         drive(p, 4'd7, 16'h8004, 3'd3, 1'b0, "R9 walk");
         settle();
         check("R9", "word order", 16'(ea_out >> 1), 16'(order[k]));
         p = ptr_wb;
      end
      check("R9", "walk returns to start", p, 16'h0000);

      // random mix, tagged by the rule in force
      for (int k = 0; k < 400; k++) begin
         logic [15:0] rp, rc;
         logic [3:0] ri;
         logic [2:0] rm;
         logic rb;
         string t;
         rp = 16'($urandom); rc = 16'($urandom); ri = 4'($urandom);
         rm = 3'($urandom); rb = ($urandom % 4) == 0;
         if ((k % 3) == 0) begin rc[15] = 1'b1; rm = (k % 2) ? 3'd3 : 3'd5; end
         if (ri != 4'd15 && rc[15] && (rm == 3'd3 || rm == 3'd5) && !rb) t = "R3 random";
         else if (rb) t = "R2 random";
         else t = "R7 random";
         drive(rp, ri, rc, rm, rb, t);
      end
      settle();

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule